// File: doc/BRIEF.md
# Width-Switchable Packed Adder/Subtractor

This block adds or subtracts two 32-bit words that hold packed integer elements. The element width is chosen per operation: four bytes, two 16-bit halves, or one 32-bit word. The datapath is a ripple of four 8-bit slices. A width select decides, at each slice boundary, whether the carry passes from the lower slice to the upper one or is replaced by a fresh element carry-in.

Subtraction uses the same slices. Operand B is inverted, and each element receives a carry-in of one at its lowest slice. The carry of each element's most significant slice is reported on a per-slice flag vector. The result and the flags are captured in one output register, so the block sits as a single stage in a pipelined vector ALU lane.

Top module: `fadd_simd`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next values of `sum_o` and `cy_o` are all zeros, whatever the operands.
- R2: Outputs change only at a rising edge. They present the operation whose inputs were sampled at the previous edge, one cycle of latency, and a new operation can start on every cycle.
- R3: With `ew_sel_i` = 2'b00, each byte of `sum_o` is the modulo-256 result of the matching bytes of the operands. No carry or borrow crosses a byte boundary.
- R4: With `ew_sel_i` = 2'b01, bits 15:0 and bits 31:16 are each an independent modulo-2^16 result. No carry or borrow crosses bit 15/16.
- R5: With `ew_sel_i` = 2'b10, `sum_o` is the modulo-2^32 result of the full words.
- R6: With `sub_i` = 1, each element of `sum_o` is A minus B modulo 2^width. With `sub_i` = 0, each element is A plus B.
- R7: `cy_o[i]` holds the carry out of slice i (bits 8i+7:8i) when slice i is the top slice of an element, and is 0 otherwise. The flagged slices are all four for bytes, slices 1 and 3 for halves, and slice 3 for a word. When adding, the flag is 1 on unsigned overflow. When subtracting, it is 1 when no borrow occurred (A >= B).
- R8: `ew_sel_i` = 2'b11 gives the same result and flags as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_a_i | input | 32 | Packed operand A |
| op_b_i | input | 32 | Packed operand B |
| ew_sel_i | input | 2 | Element width: 00 byte, 01 half, 10/11 word |
| sub_i | input | 1 | 1 subtract, 0 add |
| sum_o | output | 32 | Registered packed result |
| cy_o | output | 4 | Registered per-element carry flags, at each element's top slice |

## Verification
A wrong boundary decision has a clear signature at the ports one cycle after the operands are applied. A carry that leaks across a cut boundary adds one to the element above, or takes one from it when subtracting. A wrongly cut joined boundary drops a carry inside a wider element. Operands such as 0x00FF + 0x0001 and 0 - 1 therefore sit on every boundary in every width mode. A wrong element-start carry-in breaks every subtraction in the affected element. Wrong top-slice flags show up as carry bits set at positions that should read zero, or missing at positions that should read one.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

    localparam int SLICE_W_DEF = 8;
    localparam int SLICES_DEF  = 4;

    typedef enum logic [1:0] {
        EW_BYTE     = 2'b00,
        EW_HALF     = 2'b01,
        EW_WORD     = 2'b10,
        EW_WORD_ALT = 2'b11
    } ew_e;

    // Per-slice boundary control: first = element starts here, last = element ends here
    typedef struct packed {
        logic first;
        logic last;
    } lane_ctl_t;

    // log2 of the number of slices per element, capped at the available slices
    function automatic int unsigned ew_log2(ew_e ew, int unsigned max_log);
        int unsigned r;
        case (ew)
            EW_BYTE: r = 0;
            EW_HALF: r = 1;
            default: r = 2;
        endcase
        if (r > max_log) r = max_log;
        return r;
    endfunction

endpackage

// File: rtl/fadd_slice.sv
module fadd_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] full;
    logic [W-1:0] b_eff;

    assign b_eff = b_i ^ {W{inv_i}};
    assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
endmodule

// File: rtl/fadd_lane_ctl.sv
module fadd_lane_ctl
    import fadd_pkg::*;
#(
    parameter int SLICES = 4
) (
    input  ew_e                     ew_i,
    output lane_ctl_t [SLICES-1:0]  ctl_o
);
    localparam int unsigned MAX_LOG = $clog2(SLICES);

    int unsigned lg;
    int unsigned msk;

    always_comb begin
        lg  = ew_log2(ew_i, MAX_LOG);
        msk = (32'd1 << lg) - 32'd1;
        for (int unsigned i = 0; i < SLICES; i++) begin
            ctl_o[i].first = ((i & msk) == 0);
            ctl_o[i].last  = (((i + 1) & msk) == 0);
        end
    end

    // R7: number of element-top slices equals the number of elements
    always_comb begin
        a_r7_top_count: assert ($countones(ctl_o) == 2 * (SLICES >> lg))
            else $error("a_r7_top_count");
    end
endmodule

// File: rtl/fadd_simd.sv
module fadd_simd
    import fadd_pkg::*;
#(
    parameter int SLICE_W = SLICE_W_DEF,
    parameter int SLICES  = SLICES_DEF,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [SLICE_W*SLICES-1:0]   op_a_i,
    input  logic [SLICE_W*SLICES-1:0]   op_b_i,
    input  logic [1:0]                  ew_sel_i,
    input  logic                        sub_i,
    output logic [SLICE_W*SLICES-1:0]   sum_o,
    output logic [SLICES-1:0]           cy_o
);
    localparam int DW = SLICE_W * SLICES;
    localparam int HW = DW / 2;

    ew_e ew;
    assign ew = ew_e'(ew_sel_i);

    lane_ctl_t [SLICES-1:0] ctl;

    fadd_lane_ctl #(.SLICES(SLICES)) u_ctl (
        .ew_i  (ew),
        .ctl_o (ctl)
    );

    logic [DW-1:0]     sum_c;
    logic [SLICES-1:0] cy_c;

    for (genvar i = 0; i < SLICES; i++) begin : g_lane
        logic               cin;
        logic               cout;
        logic [SLICE_W-1:0] s;

        if (i == 0) begin : g_base
            // Slice 0 always opens an element
            assign cin = ctl[0].first ? sub_i : 1'b0;
        end else begin : g_link
            assign cin = ctl[i].first ? sub_i : g_lane[i-1].cout;
        end

        fadd_slice #(.W(SLICE_W)) u_slice (
            .a_i    (op_a_i[i*SLICE_W +: SLICE_W]),
            .b_i    (op_b_i[i*SLICE_W +: SLICE_W]),
            .inv_i  (sub_i),
            .cin_i  (cin),
            .sum_o  (s),
            .cout_o (cout)
        );

        assign sum_c[i*SLICE_W +: SLICE_W] = s;
        assign cy_c[i] = ctl[i].last & cout;
    end

    if (OUT_REG) begin : g_reg
        logic [DW-1:0]     sum_q;
        logic [SLICES-1:0] cy_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                sum_q <= '0;
                cy_q  <= '0;
            end else begin
                sum_q <= sum_c;
                cy_q  <= cy_c;
            end
        end

        assign sum_o = sum_q;
        assign cy_o  = cy_q;

        // R1: reset clears the outputs
        a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(rst_i) |-> (sum_o == '0 && cy_o == '0))
            else $error("a_r1_reset_clear");

        // R3: lowest byte in byte mode, add
        a_r3_byte_add: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(ew_sel_i) == 2'b00 && !$past(sub_i)) |->
            sum_o[SLICE_W-1:0] == $past(op_a_i[SLICE_W-1:0]) + $past(op_b_i[SLICE_W-1:0]))
            else $error("a_r3_byte_add");

        // R4: upper half independent in half mode
        a_r4_half_add: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(ew_sel_i) == 2'b01 && !$past(sub_i)) |->
            sum_o[DW-1:HW] == $past(op_a_i[DW-1:HW]) + $past(op_b_i[DW-1:HW]))
            else $error("a_r4_half_add");

        // R5: full word add
        a_r5_word_add: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(ew_sel_i) == 2'b10 && !$past(sub_i)) |->
            sum_o == $past(op_a_i) + $past(op_b_i))
            else $error("a_r5_word_add");

        // R6: full word subtract
        a_r6_word_sub: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(ew_sel_i) == 2'b10 && $past(sub_i)) |->
            sum_o == $past(op_a_i) - $past(op_b_i))
            else $error("a_r6_word_sub");

        // R7: only the top slice may flag in word mode
        a_r7_flag_mask: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(ew_sel_i[1])) |-> cy_o[SLICES-2:0] == '0)
            else $error("a_r7_flag_mask");
    end else begin : g_comb
        assign sum_o = sum_c;
        assign cy_o  = cy_c;
    end
endmodule

// File: tb/fadd_simd_bench.sv
`timescale 1ns/1ps
module fadd_simd_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = 32'hDEAD_BEEF;
    logic [31:0] b = 32'h1234_5678;
    logic [1:0]  ew = 2'b10;
    logic        sub = 1'b0;
    logic [31:0] sum;
    logic [3:0]  cy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fadd_simd u_fadd_simd (
        .clk_i    (clk),
        .rst_i    (rst),
        .op_a_i   (a),
        .op_b_i   (b),
        .ew_sel_i (ew),
        .sub_i    (sub),
        .sum_o    (sum),
        .cy_o     (cy)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  ew;
        logic        sub;
        logic [31:0] res;
        logic [3:0]  cy;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0102_FF80, 32'h01FF_0180, 2'b00, 1'b0, 32'h0201_0000, 4'b0111},
        '{32'h1000_05FF, 32'h0101_0500, 2'b00, 1'b1, 32'h0FFF_00FF, 4'b1011},
        '{32'h00FF_00FF, 32'h0001_0001, 2'b00, 1'b0, 32'h0000_0000, 4'b0101},
        '{32'h1234_FFFF, 32'h0001_0001, 2'b01, 1'b0, 32'h1235_0000, 4'b0010},
        '{32'h0001_8000, 32'h0002_0001, 2'b01, 1'b1, 32'hFFFF_7FFF, 4'b0010},
        '{32'h0000_0000, 32'h0000_0001, 2'b01, 1'b1, 32'h0000_FFFF, 4'b1000},
        '{32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, 32'h0000_0000, 4'b1000},
        '{32'h1234_5678, 32'h1111_1111, 2'b10, 1'b0, 32'h2345_6789, 4'b0000},
        '{32'h0000_0000, 32'h0000_0001, 2'b10, 1'b1, 32'hFFFF_FFFF, 4'b0000},
        '{32'h8000_0000, 32'h0000_0001, 2'b10, 1'b1, 32'h7FFF_FFFF, 4'b1000},
        '{32'h0000_00FF, 32'h0000_0001, 2'b11, 1'b0, 32'h0000_0100, 4'b0000},
        '{32'h0000_0100, 32'h0000_0001, 2'b11, 1'b1, 32'h0000_00FF, 4'b1000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic string wreq(input logic [1:0] w, input logic s);
        string r;
        case (w)
            2'b00: r = "R3";
            2'b01: r = "R4";
            2'b10: r = "R5";
            default: r = "R8";
        endcase
        return s ? {r, "+R6"} : r;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with nonzero operands applied
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sum after reset", sum, 32'h0);
        chk("R1 flags after reset", {28'h0, cy}, 32'h0);

        rst = 1'b0;
        // Vectors applied back to back, one per cycle (R2 throughput)
        for (int i = 0; i < NV; i++) begin
            a = VEC[i].a; b = VEC[i].b; ew = VEC[i].ew; sub = VEC[i].sub;
            @(posedge clk);
            #1;
            chk($sformatf("%s result vec%0d", wreq(VEC[i].ew, VEC[i].sub), i), sum, VEC[i].res);
            chk($sformatf("R7 flags vec%0d", i), {28'h0, cy}, {28'h0, VEC[i].cy});
        end

        // R2: output holds until the next edge after inputs change
        a = 32'hFFFF_FFFF; b = 32'h0000_0001; ew = 2'b10; sub = 1'b0;
        #1;
        chk("R2 output held before edge", sum, VEC[NV-1].res);
        @(posedge clk);
        #1;
        chk("R2 result one edge later", sum, 32'h0);
        chk("R7 word carry", {28'h0, cy}, 32'h8);

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset sum", sum, 32'h0);
        chk("R1 mid-run reset flags", {28'h0, cy}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule